// File: doc/BRIEF.md
# Accumulator Load and Exchange Unit

This block carries out the data-movement half of an 8-bit controller: it loads the accumulator or swaps the accumulator with one byte of data memory. An already decoded command arrives with a one-cycle `start` strobe. The command gives the operation, an addressing mode, a choice between the two pointer registers, a post-step control and an operand byte. The unit owns the accumulator and both pointer registers. It talks to a single-port, byte-wide data memory whose read data appears one clock after the address.

There are three addressing forms. Direct mode takes the address from the operand. Indirect mode takes it from the chosen pointer, and that pointer can be stepped up or down once the access is over. Immediate mode uses the operand itself as the data and leaves memory alone. `busy` covers each operation from the clock after `start`, and `done` marks its end for one clock. An exchange request in immediate mode is refused and reported on `err`. Preset inputs let the surrounding logic set the accumulator and the pointers while the unit is idle.

Top module: `acc_xfer_unit`

## Requirements
- R1: In direct mode (`mode`=00) the memory address of the read, and of the exchange write, is `operand`.
- R2: In indirect mode (`mode`=01) the memory address is the value, at the clock that accepts `start`, of pointer B when `ptr_sel`=0 or of pointer X when `ptr_sel`=1.
- R3: In indirect mode, `post_mod`=01 adds one to the chosen pointer and `post_mod`=10 subtracts one, modulo 256, after the access. The access itself uses the old value. The pointer that was not chosen never changes. `post_mod`=00 or 11, and any mode other than indirect, leave both pointers unchanged.
- R4: A load (`op_xchg`=0) copies the addressed byte into the accumulator and never asserts `mem_we`.
- R5: An exchange (`op_xchg`=1) puts the old memory byte in the accumulator and writes the old accumulator value back to the same address, using exactly one write cycle.
- R6: In immediate mode (`mode`=10) a load sets the accumulator to `operand`, `mem_we` stays low and `done` is high in the first cycle after the accepting clock.
- R7: An exchange in immediate mode, or any command with `mode`=11, is illegal. `err` is high for the one cycle after the accepting clock, `done` does not rise, and the accumulator and pointers keep their values.
- R8: A memory load raises `done` in the third cycle after the accepting clock and an exchange in the fourth. `done` lasts one cycle, `busy` is high from the accepting clock until the end of the `done` cycle, and `start` is ignored while `busy` is high.
- R9: Synchronous active-high `rst` clears the accumulator, B and X to 00 and leaves `busy`, `done`, `err` and `mem_we` low.
- R10: While the unit is idle and `start` is low, `preset_a`, `preset_b` and `preset_x` each load `preset_val` into their register at the clock. At any other time the preset inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Command strobe, accepted when idle |
| op_xchg | input | 1 | 0 = load, 1 = exchange |
| mode | input | 2 | 00 direct, 01 indirect, 10 immediate, 11 illegal |
| ptr_sel | input | 1 | 0 = pointer B, 1 = pointer X |
| post_mod | input | 2 | 01 increment, 10 decrement, else none |
| operand | input | DW | Address (direct) or data (immediate) |
| preset_a | input | 1 | Load accumulator from preset_val |
| preset_b | input | 1 | Load pointer B from preset_val |
| preset_x | input | 1 | Load pointer X from preset_val |
| preset_val | input | DW | Preset data |
| mem_addr | output | DW | Data memory address |
| mem_wdata | output | DW | Data memory write data |
| mem_we | output | 1 | Data memory write enable |
| mem_rdata | input | DW | Data memory read data, one cycle after address |
| acc | output | DW | Accumulator |
| ptr_b | output | DW | Pointer B |
| ptr_x | output | DW | Pointer X |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-command pulse |

## Verification
The hardest case to reach is a pointer step that wraps: a post-decrement from 00 or a post-increment from FF, made while the other pointer holds a value that would show any stray write. Random commands almost never produce those end values. The bench therefore presets B or X to 00 or FF through the preset inputs before issuing directed indirect commands. Random traffic then keeps feeding the pointers back into the loop. A second hard case is a `start` that is still high at the `done` cycle. This is reached by holding `start` high across back-to-back operations.

// File: rtl/acc_xfer_unit.sv
module acc_xfer_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          op_xchg,
  input  logic [1:0]    mode,
  input  logic          ptr_sel,
  input  logic [1:0]    post_mod,
  input  logic [DW-1:0] operand,
  input  logic          preset_a,
  input  logic          preset_b,
  input  logic          preset_x,
  input  logic [DW-1:0] preset_val,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] ptr_b,
  output logic [DW-1:0] ptr_x,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam logic [1:0] M_DIR = 2'd0, M_IND = 2'd1, M_IMM = 2'd2;
  localparam logic [1:0] PM_INC = 2'd1, PM_DEC = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CAP, S_WR, S_FIN} st_t;

  st_t           st;
  logic [DW-1:0] a_q, b_q, x_q, adr_q, old_q;
  logic          xchg_q, sel_q, ind_q, err_q;
  logic [1:0]    pm_q;

  wire           idle    = (st == S_IDLE);
  wire           go      = idle && start;
  wire           bad     = (mode == 2'd3) || (op_xchg && mode == M_IMM);
  wire [DW-1:0]  sel_ptr = ptr_sel ? x_q : b_q;
  wire [DW-1:0]  cur     = sel_q ? x_q : b_q;
  wire           bump    = ind_q && (pm_q == PM_INC || pm_q == PM_DEC);
  wire [DW-1:0]  nxt     = (pm_q == PM_INC) ? cur + DW'(1) : cur - DW'(1);
  wire           ptr_upd = bump && ((st == S_CAP && !xchg_q) || st == S_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      x_q    <= '0;
      adr_q  <= '0;
      old_q  <= '0;
      xchg_q <= 1'b0;
      sel_q  <= 1'b0;
      ind_q  <= 1'b0;
      pm_q   <= 2'd0;
      err_q  <= 1'b0;
    end else begin
      err_q <= go && bad;
      unique case (st)
        S_IDLE: begin
          if (go) begin
            if (!bad) begin
              xchg_q <= op_xchg;
              sel_q  <= ptr_sel;
              pm_q   <= post_mod;
              ind_q  <= (mode == M_IND);
              adr_q  <= (mode == M_IND) ? sel_ptr : operand;
              if (mode == M_IMM) begin
                a_q <= operand;
                st  <= S_FIN;
              end else begin
                st <= S_RD;
              end
            end
          end else begin
            if (preset_a) a_q <= preset_val;
            if (preset_b) b_q <= preset_val;
            if (preset_x) x_q <= preset_val;
          end
        end
        S_RD:  st <= S_CAP;
        S_CAP: begin
          a_q   <= mem_rdata;
          old_q <= a_q;
          st    <= xchg_q ? S_WR : S_FIN;
        end
        S_WR:  st <= S_FIN;
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (ptr_upd) begin
        if (sel_q) x_q <= nxt;
        else       b_q <= nxt;
      end
    end
  end

  assign mem_addr  = adr_q;
  assign mem_wdata = old_q;
  assign mem_we    = (st == S_WR);
  assign acc       = a_q;
  assign ptr_b     = b_q;
  assign ptr_x     = x_q;
  assign busy      = !idle;
  assign done      = (st == S_FIN);
  assign err       = err_q;

  wire unused_ok = ^{M_DIR};
endmodule

// File: rtl/acc_xfer_chk.sv
module acc_xfer_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          op_xchg,
  input logic [1:0]    mode,
  input logic          mem_we,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] ptr_b,
  input logic [DW-1:0] ptr_x,
  input logic          busy,
  input logic          done,
  input logic          err
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_we_in_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  a_r6_imm_fast: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !op_xchg && mode == 2'd2) |=> (done && !mem_we));

  a_r7_err_hold: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(acc) && $stable(ptr_b) && $stable(ptr_x) && !done));

  a_r3_b_step: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && ptr_b != $past(ptr_b)) |->
      (ptr_b == $past(ptr_b) + DW'(1) || ptr_b == $past(ptr_b) - DW'(1)));

  a_r3_x_step: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && ptr_x != $past(ptr_x)) |->
      (ptr_x == $past(ptr_x) + DW'(1) || ptr_x == $past(ptr_x) - DW'(1)));

  a_r3_one_ptr: assert property (@(posedge clk) disable iff (rst)
    $past(busy) |-> !(ptr_b != $past(ptr_b) && ptr_x != $past(ptr_x)));

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (acc == '0 && ptr_b == '0 && ptr_x == '0 && !busy && !done && !err));
endmodule

bind acc_xfer_unit acc_xfer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op_xchg(op_xchg), .mode(mode),
  .mem_we(mem_we), .acc(acc), .ptr_b(ptr_b), .ptr_x(ptr_x),
  .busy(busy), .done(done), .err(err)
);

// File: tb/sim_acc_xfer_unit.sv
module sim_acc_xfer_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_xchg = 1'b0, ptr_sel = 1'b0;
  logic [1:0] mode = 2'd0, post_mod = 2'd0;
  logic [7:0] operand = 8'h00, preset_val = 8'h00;
  logic preset_a = 1'b0, preset_b = 1'b0, preset_x = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, acc, ptr_b, ptr_x;
  logic mem_we, busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_xfer_unit #(.DW(DW)) u0 (
    .clk(clk), .rst(rst), .start(start), .op_xchg(op_xchg), .mode(mode),
    .ptr_sel(ptr_sel), .post_mod(post_mod), .operand(operand),
    .preset_a(preset_a), .preset_b(preset_b), .preset_x(preset_x),
    .preset_val(preset_val), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .acc(acc), .ptr_b(ptr_b),
    .ptr_x(ptr_x), .busy(busy), .done(done), .err(err)
  );

  logic [7:0] ram [256];
  logic [7:0] ref_mem [256];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  int checks = 0, errors = 0;

  // behavioural reference model
  int phase = 0;
  logic [7:0] m_a = 0, m_b = 0, m_x = 0, m_err = 0;
  logic [7:0] r_addr;
  logic r_xchg, r_sel, r_ind;
  logic [1:0] r_pm;

  task automatic m_step_ptr();
    if (r_ind && (r_pm == 2'd1 || r_pm == 2'd2)) begin
      if (r_sel) m_x = (r_pm == 2'd1) ? m_x + 8'd1 : m_x - 8'd1;
      else       m_b = (r_pm == 2'd1) ? m_b + 8'd1 : m_b - 8'd1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      phase = 0; m_a = 0; m_b = 0; m_x = 0; m_err = 0;
    end else begin
      m_err = 0;
      case (phase)
        0: begin
          if (start) begin
            if (mode == 2'd3 || (op_xchg && mode == 2'd2)) m_err = 1;
            else if (mode == 2'd2) begin m_a = operand; phase = 4; end
            else begin
              r_xchg = op_xchg; r_sel = ptr_sel; r_pm = post_mod;
              r_ind = (mode == 2'd1);
              r_addr = r_ind ? (ptr_sel ? m_x : m_b) : operand;
              phase = 1;
            end
          end else begin
            if (preset_a) m_a = preset_val;
            if (preset_b) m_b = preset_val;
            if (preset_x) m_x = preset_val;
          end
        end
        1: phase = 2;
        2: begin
          if (r_xchg) begin
            logic [7:0] t;
            t = m_a; m_a = ref_mem[r_addr]; ref_mem[r_addr] = t; phase = 3;
          end else begin
            m_a = ref_mem[r_addr]; m_step_ptr(); phase = 4;
          end
        end
        3: begin m_step_ptr(); phase = 4; end
        default: phase = 0;
      endcase
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) if (!rst) begin
    chk(acc == m_a, "R4 R5 R6 R10 acc", acc, m_a);
    chk(ptr_b == m_b, "R3 R10 ptr_b", ptr_b, m_b);
    chk(ptr_x == m_x, "R3 R10 ptr_x", ptr_x, m_x);
    chk(done == (phase == 4), "R8 done", done, phase == 4);
    chk(busy == (phase != 0), "R8 busy", busy, phase != 0);
    chk(err == m_err[0], "R7 err", err, m_err[0]);
    chk(mem_we == (phase == 3), "R5 mem_we", mem_we, phase == 3);
    if (phase == 3) chk(mem_addr == r_addr, "R1 R2 write addr", mem_addr, r_addr);
  end

  int lat; logic saw_we, saw_err, saw_done;

  task automatic do_op(input logic x, input logic [1:0] md, input logic sel,
                       input logic [1:0] pm, input logic [7:0] opnd);
    @(negedge clk);
    start = 1; op_xchg = x; mode = md; ptr_sel = sel; post_mod = pm; operand = opnd;
    @(negedge clk);
    start = 0;
    lat = 1; saw_we = 0; saw_err = 0; saw_done = 0;
    for (int i = 0; i < 8; i++) begin
      if (mem_we) saw_we = 1;
      if (err) saw_err = 1;
      if (done) begin saw_done = 1; break; end
      if (!busy && i > 0) break;
      @(negedge clk); lat++;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic preset(input logic pa, input logic pb, input logic px, input logic [7:0] v);
    @(negedge clk);
    preset_a = pa; preset_b = pb; preset_x = px; preset_val = v;
    @(negedge clk);
    preset_a = 0; preset_b = 0; preset_x = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    ram[5] = 8'h03; ref_mem[5] = 8'h03;
    repeat (3) @(negedge clk);
    chk(acc == 0 && ptr_b == 0 && ptr_x == 0 && !busy && !done && !err, "R9 reset", acc, 0);
    rst = 0;
    @(negedge clk);
    chk(acc == 0 && ptr_b == 0 && ptr_x == 0, "R9 after reset", {ptr_b, ptr_x}, 0);

    preset(1, 0, 0, 8'h62); preset(0, 1, 0, 8'h05); preset(0, 0, 1, 8'hF0);
    chk(acc == 8'h62 && ptr_b == 8'h05 && ptr_x == 8'hF0, "R10 preset", acc, 8'h62);

    do_op(1, 2'd1, 0, 2'd1, 8'h00);
    chk(acc == 8'h03, "R5 R2 xchg acc", acc, 8'h03);
    chk(ram[5] == 8'h62, "R5 xchg mem", ram[5], 8'h62);
    chk(ptr_b == 8'h06 && ptr_x == 8'hF0, "R3 post-inc", ptr_b, 8'h06);
    chk(lat == 4 && saw_we, "R8 xchg latency", lat, 4);

    do_op(0, 2'd0, 0, 2'd1, 8'h05);
    chk(acc == 8'h62 && !saw_we, "R1 R4 direct load", acc, 8'h62);
    chk(lat == 3, "R8 load latency", lat, 3);
    chk(ptr_b == 8'h06, "R3 no step in direct", ptr_b, 8'h06);

    do_op(0, 2'd2, 0, 2'd0, 8'hA6);
    chk(acc == 8'hA6 && !saw_we && lat == 1, "R6 immediate", acc, 8'hA6);

    do_op(1, 2'd2, 1, 2'd1, 8'h11);
    chk(saw_err && !saw_done && acc == 8'hA6 && ptr_x == 8'hF0, "R7 illegal xchg imm", acc, 8'hA6);
    do_op(0, 2'd3, 0, 2'd1, 8'h11);
    chk(saw_err && !saw_done && ptr_b == 8'h06, "R7 mode 11", ptr_b, 8'h06);

    preset(0, 0, 1, 8'hFF);
    do_op(0, 2'd1, 1, 2'd1, 8'h00);
    chk(ptr_x == 8'h00 && ptr_b == 8'h06, "R3 wrap up", ptr_x, 8'h00);
    chk(acc == ref_mem[8'hFF], "R2 R4 load via X", acc, ref_mem[8'hFF]);
    preset(0, 1, 0, 8'h00);
    do_op(1, 2'd1, 0, 2'd2, 8'h00);
    chk(ptr_b == 8'hFF && ptr_x == 8'h00, "R3 wrap down", ptr_b, 8'hFF);
    do_op(0, 2'd1, 0, 2'd3, 8'h00);
    chk(ptr_b == 8'hFF, "R3 post_mod 11 no step", ptr_b, 8'hFF);

    // preset while busy must be ignored
    @(negedge clk);
    start = 1; op_xchg = 0; mode = 2'd0; operand = 8'h10;
    @(negedge clk);
    start = 0; preset_a = 1; preset_b = 1; preset_val = 8'h5A;
    @(negedge clk); @(negedge clk);
    preset_a = 0; preset_b = 0;
    while (busy) @(negedge clk);
    chk(acc == ref_mem[8'h10] && ptr_b == 8'hFF, "R10 preset ignored busy", acc, ref_mem[8'h10]);

    // start held high: accepted only when idle
    @(negedge clk);
    start = 1; op_xchg = 1; mode = 2'd1; ptr_sel = 1; post_mod = 2'd1;
    repeat (20) @(negedge clk);
    start = 0;
    while (busy) @(negedge clk);
    chk(ptr_x == 8'h04, "R8 R3 held start", ptr_x, 8'h04);

    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0) preset($urandom_range(0, 1), $urandom_range(0, 1),
                              $urandom_range(0, 1), 8'($urandom));
      do_op($urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom_range(0, 1),
            2'($urandom_range(0, 3)), 8'($urandom));
    end

    @(negedge clk);
    for (int i = 0; i < 256; i++)
      if (ram[i] != ref_mem[i]) chk(0, "R4 R5 memory image", ram[i], ref_mem[i]);
    chk(1, "R4 R5 memory image done", 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule